// File: doc/BRIEF.md
# Instruction Issue Grouper

This block sits between instruction fetch and the three execution pipelines of a small superscalar core. Each cycle it looks at a window of up to three consecutive 32-bit instruction words and cuts off the longest legal issue group at its head. Every word in that group is routed to one of three issue slots: data globule 0, data globule 1 or the control pipeline. No framing field is used. A word's top bits give its class and target globule, and the group follows from the fixed slot order glob0, then glob1, then control.

Fused operations are two words, a leader and a companion, that must occupy opposite globules. Either globule may hold the leader, and one control word may follow the pair. Words that are not instructions, such as the all-ones word, indirect-branch pointer words and reserved data codes, raise a trap when they reach the head of the window. Malformed pairs raise a trap with a separate cause.

The fetcher presents the window with `in_valid` and per-word valid bits. It reads `consume_cnt` in the same cycle to know how far to advance. The routed slots, the fused flag and the trap appear on registered outputs in the cycle after the handshake.

Top module: `issue_grouper`

## Requirements
- R1: A word with bit 31 clear is a data operation. Bit 30 picks its globule: 0 routes it to the glob0 slot and 1 to the glob1 slot. A word with bit 31 set that is neither invalid form is a control word for the control slot. Slot outputs carry the routed words one cycle after the handshake.
- R2: Three kinds of word are invalid: 32'hFFFFFFFF, any word with top byte 8'hFE, and a data word with bits 29:28 = 11. At the head of the window an invalid word consumes 1 word, sets `trap` with `trap_cause` = 0 in the next cycle and fills no slot.
- R3: Only these single-operation groups issue: glob0, glob1, glob0+glob1, glob0+glob1+control, glob0+control, glob1+control, control. `consume_cnt` equals the number of words in the group.
- R4: A group ends before a word that cannot extend it in slot order. Examples are a glob0 word after a glob1 word, any word after a control word, a second word for the same globule, an invalid word, or a leader/companion after a single op. Words after the end are not consumed.
- R5: Data bits 29:28 = 01 mark a pair leader and 10 a companion. A leader followed by a companion for the opposite globule issues as a fused pair in either globule order. An optional trailing control word may join it. `fused` is set and the count is 2 or 3.
- R6: A leader whose next valid word is not a companion for the opposite globule, and a companion at the head, each consume 1 word and set `trap` with `trap_cause` = 1.
- R7: A leader at the head with no second valid word consumes 0 words and issues nothing, waiting for its companion.
- R8: `consume_cnt` is 0 when `in_valid`, `word_vld[0]` or `in_ready` is low. Word 2 is used only when word 1 is also valid.
- R9: While `rst_n` is low, `in_ready` and all issue outputs are low. `in_ready` is high from the first clock edge after reset.
- R10: Slot valids, `fused` and `trap` are set only in the cycle after a handshake that consumed words. In any other cycle they are all low.
- R11: The all-zero word (no-operation) issues as a single glob0 operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window is presented |
| in_ready | output | 1 | Block accepts a window this cycle |
| word_vld | input | 3 | Per-word valid bits, word 0 first |
| word0 | input | 32 | Head word of the window |
| word1 | input | 32 | Second word |
| word2 | input | 32 | Third word |
| consume_cnt | output | 2 | Words taken from the window this cycle |
| g0_vld | output | 1 | Glob0 slot holds an operation |
| g0_word | output | 32 | Glob0 slot word |
| g1_vld | output | 1 | Glob1 slot holds an operation |
| g1_word | output | 32 | Glob1 slot word |
| c_vld | output | 1 | Control slot holds an operation |
| c_word | output | 32 | Control slot word |
| fused | output | 1 | Glob0 and glob1 slots form one fused pair |
| trap | output | 1 | Head word trapped |
| trap_cause | output | 1 | 0 invalid word, 1 illegal pair |

## Verification
The hardest situations to reach are a pair leader whose window is cut short and a leader followed by a valid word of the wrong kind, because both depend on the per-word valid bits and the word classes lining up together. Random windows are drawn from weighted instruction kinds with partial and gapped valid masks, so these cases keep recurring. Directed windows pin down each one together with the reversed pair order and the traps. The expected group comes from longest-prefix matching against a list of legal shapes, which is a different formulation from the decision logic in the design.

// File: rtl/igrp_pkg.sv
package igrp_pkg;
  localparam int WORD_W  = 32;
  localparam int WIN_N   = 3;
  localparam int CNT_W   = $clog2(WIN_N + 1);
  localparam int IDX_W   = $clog2(WIN_N);
  localparam logic [7:0] PTR_TAG = 8'hFE;

  typedef enum logic [2:0] {
    K_INV, K_S0, K_S1, K_L0, K_L1, K_Q0, K_Q1, K_CTL
  } kind_e;

  function automatic kind_e classify(input logic [WORD_W-1:0] w);
    if (w == {WORD_W{1'b1}} || w[WORD_W-1 -: 8] == PTR_TAG) return K_INV;
    if (w[WORD_W-1]) return K_CTL;
    case (w[WORD_W-3 -: 2])
      2'b00:   return w[WORD_W-2] ? K_S1 : K_S0;
      2'b01:   return w[WORD_W-2] ? K_L1 : K_L0;
      2'b10:   return w[WORD_W-2] ? K_Q1 : K_Q0;
      default: return K_INV;
    endcase
  endfunction
endpackage

// File: rtl/igrp_word_class.sv
module igrp_word_class
  import igrp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output kind_e             kind
);
  assign kind = classify(word);
endmodule

// File: rtl/igrp_pattern.sv
module igrp_pattern
  import igrp_pkg::*;
(
  input  kind_e            k0,
  input  kind_e            k1,
  input  kind_e            k2,
  input  logic [CNT_W-1:0] avail,
  output logic [CNT_W-1:0] cnt,
  output logic             v0,
  output logic             v1,
  output logic             vc,
  output logic [IDX_W-1:0] s0,
  output logic [IDX_W-1:0] s1,
  output logic [IDX_W-1:0] sc,
  output logic             pair,
  output logic             trp,
  output logic             cause
);
  logic has1, has2;
  assign has1 = avail >= CNT_W'(2);
  assign has2 = avail >= CNT_W'(3);

  always_comb begin
    cnt = '0; v0 = 1'b0; v1 = 1'b0; vc = 1'b0;
    s0 = '0; s1 = '0; sc = '0;
    pair = 1'b0; trp = 1'b0; cause = 1'b0;
    if (avail != '0) begin
      case (k0)
        K_INV: begin trp = 1'b1; cnt = CNT_W'(1); end
        K_Q0, K_Q1: begin trp = 1'b1; cause = 1'b1; cnt = CNT_W'(1); end
        K_L0, K_L1: begin
          if (has1) begin
            if ((k0 == K_L0 && k1 == K_Q1) || (k0 == K_L1 && k1 == K_Q0)) begin
              v0 = 1'b1; v1 = 1'b1; pair = 1'b1; cnt = CNT_W'(2);
              s0 = (k0 == K_L0) ? IDX_W'(0) : IDX_W'(1);
              s1 = (k0 == K_L0) ? IDX_W'(1) : IDX_W'(0);
              if (has2 && k2 == K_CTL) begin
                vc = 1'b1; sc = IDX_W'(2); cnt = CNT_W'(3);
              end
            end else begin
              trp = 1'b1; cause = 1'b1; cnt = CNT_W'(1);
            end
          end
        end
        K_S0: begin
          v0 = 1'b1; s0 = IDX_W'(0); cnt = CNT_W'(1);
          if (has1 && k1 == K_S1) begin
            v1 = 1'b1; s1 = IDX_W'(1); cnt = CNT_W'(2);
            if (has2 && k2 == K_CTL) begin
              vc = 1'b1; sc = IDX_W'(2); cnt = CNT_W'(3);
            end
          end else if (has1 && k1 == K_CTL) begin
            vc = 1'b1; sc = IDX_W'(1); cnt = CNT_W'(2);
          end
        end
        K_S1: begin
          v1 = 1'b1; s1 = IDX_W'(0); cnt = CNT_W'(1);
          if (has1 && k1 == K_CTL) begin
            vc = 1'b1; sc = IDX_W'(1); cnt = CNT_W'(2);
          end
        end
        default: begin vc = 1'b1; sc = IDX_W'(0); cnt = CNT_W'(1); end
      endcase
    end
  end
endmodule

// File: rtl/issue_grouper.sv
module issue_grouper
  import igrp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WIN_N-1:0]  word_vld,
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  input  logic [WORD_W-1:0] word2,
  output logic [CNT_W-1:0]  consume_cnt,
  output logic              g0_vld,
  output logic [WORD_W-1:0] g0_word,
  output logic              g1_vld,
  output logic [WORD_W-1:0] g1_word,
  output logic              c_vld,
  output logic [WORD_W-1:0] c_word,
  output logic              fused,
  output logic              trap,
  output logic              trap_cause
);
  logic [WORD_W-1:0] win [WIN_N];
  kind_e             kinds [WIN_N];
  assign win[0] = word0;
  assign win[1] = word1;
  assign win[2] = word2;

  for (genvar i = 0; i < WIN_N; i++) begin : g_cls
    igrp_word_class u_cls (.word(win[i]), .kind(kinds[i]));
  end

  // contiguous run of valid words, zero when not accepting
  function automatic logic [CNT_W-1:0] run_len(input logic [WIN_N-1:0] v);
    logic [CNT_W-1:0] n;
    logic             open;
    n = '0; open = 1'b1;
    for (int i = 0; i < WIN_N; i++) begin
      open = open & v[i];
      if (open) n = n + CNT_W'(1);
    end
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] pick(input logic [IDX_W-1:0] s,
                                             input logic [WORD_W-1:0] a,
                                             input logic [WORD_W-1:0] b,
                                             input logic [WORD_W-1:0] c);
    case (s)
      IDX_W'(0): return a;
      IDX_W'(1): return b;
      default:   return c;
    endcase
  endfunction

  logic             rdy_q;
  logic [CNT_W-1:0] avail, grp_cnt;
  logic             pv0, pv1, pvc, ppair, ptrp, pcause;
  logic [IDX_W-1:0] ps0, ps1, psc;
  logic             grp_fire;

  assign avail = (in_valid && rdy_q) ? run_len(word_vld) : '0;

  igrp_pattern u_pat (
    .k0(kinds[0]), .k1(kinds[1]), .k2(kinds[2]), .avail(avail),
    .cnt(grp_cnt), .v0(pv0), .v1(pv1), .vc(pvc),
    .s0(ps0), .s1(ps1), .sc(psc),
    .pair(ppair), .trp(ptrp), .cause(pcause)
  );

  assign grp_fire    = grp_cnt != '0;
  assign consume_cnt = grp_cnt;
  assign in_ready    = rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      g0_vld <= 1'b0; g1_vld <= 1'b0; c_vld <= 1'b0;
      g0_word <= '0; g1_word <= '0; c_word <= '0;
      fused <= 1'b0; trap <= 1'b0; trap_cause <= 1'b0;
    end else begin
      rdy_q      <= 1'b1;
      g0_vld     <= grp_fire & pv0;
      g1_vld     <= grp_fire & pv1;
      c_vld      <= grp_fire & pvc;
      fused      <= grp_fire & ppair;
      trap       <= grp_fire & ptrp;
      trap_cause <= grp_fire & ptrp & pcause;
      if (grp_fire) begin
        g0_word <= pick(ps0, word0, word1, word2);
        g1_word <= pick(ps1, word0, word1, word2);
        c_word  <= pick(psc, word0, word1, word2);
      end
    end
  end
endmodule

// File: rtl/igrp_checker.sv
module igrp_checker
  import igrp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [CNT_W-1:0] consume_cnt,
  input logic             grp_fire,
  input logic             g0_vld,
  input logic             g1_vld,
  input logic             c_vld,
  input logic             fused,
  input logic             trap,
  input logic             trap_cause
);
  // R2
  trap_no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !(g0_vld || g1_vld || c_vld || fused));
  // R5
  fused_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fused |-> (g0_vld && g1_vld));
  // R8
  cnt_needs_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume_cnt != '0) |-> (in_valid && in_ready));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_fire |=> !(g0_vld || g1_vld || c_vld || fused || trap));
  // R3
  slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_fire |=> (trap || $countones({g0_vld, g1_vld, c_vld}) == 32'($past(consume_cnt))));
  // R6
  cause_with_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_cause |-> trap);
endmodule

bind issue_grouper igrp_checker u_igrp_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .consume_cnt(consume_cnt), .grp_fire(grp_fire),
  .g0_vld(g0_vld), .g1_vld(g1_vld), .c_vld(c_vld),
  .fused(fused), .trap(trap), .trap_cause(trap_cause)
);

// File: tb/issue_grouper_bench.sv
module issue_grouper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B_INV = 0, B_S0 = 1, B_S1 = 2, B_L0 = 3, B_L1 = 4,
                 B_Q0 = 5, B_Q1 = 6, B_CTL = 7;
  localparam int NSHP = 11;
  localparam int SHAPE [NSHP][3] = '{
    '{B_S0, B_S1, B_CTL}, '{B_L0, B_Q1, B_CTL}, '{B_L1, B_Q0, B_CTL},
    '{B_S0, B_S1, -1}, '{B_S0, B_CTL, -1}, '{B_S1, B_CTL, -1},
    '{B_L0, B_Q1, -1}, '{B_L1, B_Q0, -1},
    '{B_S0, -1, -1}, '{B_S1, -1, -1}, '{B_CTL, -1, -1}};

  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_ready;
  logic [2:0]  word_vld = '0;
  logic [31:0] word0 = '0, word1 = '0, word2 = '0;
  logic [1:0]  consume_cnt;
  logic        g0_vld, g1_vld, c_vld, fused, trap, trap_cause;
  logic [31:0] g0_word, g1_word, c_word;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_grouper u_issue_grouper (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bkind(input logic [31:0] w);
    if (w == 32'hFFFF_FFFF || w[31:24] == 8'hFE) return B_INV;
    if (w[31]) return B_CTL;
    case (w[29:28])
      2'b00: return w[30] ? B_S1 : B_S0;
      2'b01: return w[30] ? B_L1 : B_L0;
      2'b10: return w[30] ? B_Q1 : B_Q0;
      default: return B_INV;
    endcase
  endfunction

  function automatic int slot_of(input int k);
    if (k == B_S0 || k == B_L0 || k == B_Q0) return 0;
    if (k == B_S1 || k == B_L1 || k == B_Q1) return 1;
    return 2;
  endfunction

  function automatic logic [31:0] mk(input int k, input logic [31:0] r);
    logic [31:0] w;
    case (k)
      B_CTL: begin
        w = {1'b1, r[30:0]};
        if (w[31:24] == 8'hFE) w[24] = 1'b1;
        if (w == 32'hFFFF_FFFF) w[0] = 1'b0;
      end
      B_INV: case (r[1:0])
        2'd0: w = 32'hFFFF_FFFF;
        2'd1: w = {8'hFE, r[23:0]};
        default: w = {1'b0, r[30], 2'b11, r[27:0]};
      endcase
      default: w = {1'b0, (k == B_S1 || k == B_L1 || k == B_Q1),
                    (k == B_L0 || k == B_L1) ? 2'b01 :
                    (k == B_Q0 || k == B_Q1) ? 2'b10 : 2'b00, r[27:0]};
    endcase
    return w;
  endfunction

  task automatic step(input bit iv, input logic [2:0] v, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] c, input string req);
    logic [31:0] w [3];
    int k [3];
    int n, m, ecnt;
    bit etrap, ecause, efused;
    bit ev [3];
    logic [31:0] ew [3];
    w[0] = a; w[1] = b; w[2] = c;
    for (int i = 0; i < 3; i++) begin k[i] = bkind(w[i]); ev[i] = 0; ew[i] = '0; end
    n = (!iv || !v[0]) ? 0 : (!v[1] ? 1 : (!v[2] ? 2 : 3));
    m = 0;
    for (int s = 0; s < NSHP && m == 0; s++) begin
      int len = (SHAPE[s][2] >= 0) ? 3 : (SHAPE[s][1] >= 0) ? 2 : 1;
      bit ok = (len <= n);
      for (int j = 0; j < len; j++) if (SHAPE[s][j] != k[j]) ok = 0;
      if (ok) m = len;
    end
    etrap = 0; ecause = 0; efused = 0; ecnt = 0;
    if (n > 0) begin
      if (m > 0) begin
        ecnt = m;
        efused = (k[0] == B_L0 || k[0] == B_L1);
        for (int j = 0; j < m; j++) begin ev[slot_of(k[j])] = 1; ew[slot_of(k[j])] = w[j]; end
      end else if (k[0] == B_INV) begin ecnt = 1; etrap = 1; end
      else if (k[0] == B_Q0 || k[0] == B_Q1 || n >= 2) begin ecnt = 1; etrap = 1; ecause = 1; end
    end
    @(negedge clk);
    in_valid = iv; word_vld = v; word0 = a; word1 = b; word2 = c;
    #1;
    chk(consume_cnt == 2'(ecnt), req, "consume_cnt", 64'(consume_cnt), 64'(ecnt));
    @(posedge clk); #1;
    chk({g0_vld, g1_vld, c_vld} == {ev[0], ev[1], ev[2]}, req, "slot valids",
        64'({g0_vld, g1_vld, c_vld}), 64'({ev[0], ev[1], ev[2]}));
    chk({trap, trap_cause, fused} == {etrap, ecause, efused}, req, "trap/cause/fused",
        64'({trap, trap_cause, fused}), 64'({etrap, ecause, efused}));
    if (ev[0]) chk(g0_word == ew[0], "R1", "g0_word", 64'(g0_word), 64'(ew[0]));
    if (ev[1]) chk(g1_word == ew[1], "R1", "g1_word", 64'(g1_word), 64'(ew[1]));
    if (ev[2]) chk(c_word == ew[2], "R1", "c_word", 64'(c_word), 64'(ew[2]));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #1;
    // R9
    chk(in_ready == 1'b0, "R9", "in_ready in reset", 64'(in_ready), 64'(0));
    chk({g0_vld, g1_vld, c_vld, trap} == 4'b0, "R9", "outputs in reset",
        64'({g0_vld, g1_vld, c_vld, trap}), 64'(0));
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(in_ready == 1'b1, "R9", "in_ready after reset", 64'(in_ready), 64'(1));

    step(1, 3'b001, 32'h0, 32'h0, 32'h0, "R11");
    step(1, 3'b111, 32'hFFFF_FFFF, mk(B_S0, 1), mk(B_CTL, 2), "R2");
    step(1, 3'b111, 32'hFE12_3456, mk(B_S0, 1), mk(B_CTL, 2), "R2");
    step(1, 3'b011, mk(B_INV, 32'h2), mk(B_S1, 5), 0, "R2");
    step(1, 3'b111, mk(B_S0, 7), mk(B_S1, 8), mk(B_CTL, 9), "R3");
    step(1, 3'b111, mk(B_S0, 7), mk(B_CTL, 8), mk(B_S1, 9), "R3");
    step(1, 3'b111, mk(B_S1, 7), mk(B_CTL, 8), mk(B_S0, 9), "R3");
    step(1, 3'b111, mk(B_CTL, 7), mk(B_S0, 8), mk(B_S1, 9), "R4");
    step(1, 3'b111, mk(B_S1, 3), mk(B_S0, 4), mk(B_CTL, 5), "R4");
    step(1, 3'b111, mk(B_S0, 3), mk(B_S0, 4), mk(B_S1, 5), "R4");
    step(1, 3'b111, mk(B_S0, 3), 32'hFFFF_FFFF, mk(B_CTL, 5), "R4");
    step(1, 3'b111, mk(B_S0, 3), mk(B_Q1, 4), mk(B_CTL, 5), "R4");
    step(1, 3'b111, mk(B_L0, 11), mk(B_Q1, 12), mk(B_CTL, 13), "R5");
    step(1, 3'b111, mk(B_L1, 11), mk(B_Q0, 12), mk(B_S0, 13), "R5");
    step(1, 3'b111, mk(B_L0, 11), mk(B_S1, 12), mk(B_CTL, 13), "R6");
    step(1, 3'b111, mk(B_L1, 11), mk(B_Q1, 12), mk(B_CTL, 13), "R6");
    step(1, 3'b111, mk(B_Q1, 11), mk(B_CTL, 12), 0, "R6");
    step(1, 3'b001, mk(B_L1, 11), mk(B_Q0, 12), 0, "R7");
    step(1, 3'b101, mk(B_L0, 11), mk(B_Q1, 12), 0, "R7");
    step(0, 3'b111, mk(B_S0, 1), mk(B_S1, 2), mk(B_CTL, 3), "R8");
    step(1, 3'b101, mk(B_S0, 1), mk(B_S1, 2), mk(B_CTL, 3), "R8");
    step(1, 3'b000, mk(B_CTL, 1), 0, 0, "R10");

    for (int t = 0; t < 600; t++) begin
      int pick [8] = '{B_S0, B_S1, B_CTL, B_L0, B_L1, B_Q0, B_Q1, B_INV};
      logic [31:0] r [3];
      logic [2:0] v;
      int kk [3];
      for (int j = 0; j < 3; j++) begin
        int u = $urandom_range(0, 19);
        kk[j] = (u < 13) ? pick[u % 3] : pick[3 + (u % 5)];
        r[j] = mk(kk[j], $urandom());
      end
      case ($urandom_range(0, 5))
        0: v = 3'b001; 1: v = 3'b011; 2: v = 3'b101; default: v = 3'b111;
      endcase
      step($urandom_range(0, 9) != 0, v, r[0], r[1], r[2], "R3");
    end
    finish_run();
  end
endmodule